// File: doc/BRIEF.md
# Power-Domain Boundary Isolation Unit

This unit guards the boundary between an always-on management domain and a user domain whose supplies may be switched off. Signals leaving the management side toward the user domain are released only while the user primary core supply reports power good. Otherwise each one is held non-driving: its output enable is low and its value is forced to zero. The release waits for a two-flop synchronized copy of power good. Removal acts at once, without waiting for the synchronizer.

Signals entering the management side from the user domain are ANDed with enable bits that software writes. These signals are 128 logic-analyzer inputs, three interrupt lines, and the bus read data with its acknowledge. A floating or unpowered user signal whose enable is clear therefore never reaches the management logic. A small register port holds the enable bits and a read-only copy of the four supply status flags. Only the management side can reach this port.

Top module: `pd_iso_unit`

## Requirements
- R1: `usr_oe` is 1 only while `pg_raw[3]` (user-1 core supply good) is 1 and its synchronized copy is 1. While `usr_oe` is 0, `usr_out` is all zeros; while it is 1, `usr_out` equals `mgmt_out`.
- R2: When `pg_raw[3]` rises, `usr_oe` rises after exactly two rising clock edges. When it falls, `usr_oe` drops in the same cycle. The other `pg_raw` bits have no effect on `usr_oe`.
- R3: `mgmt_la[i]` equals `usr_la[i]` AND enable bit i. An unknown or floating `usr_la[i]` whose enable is clear gives 0.
- R4: The logic-analyzer enables sit in four 32-bit words at byte addresses 0x20, 0x24, 0x28 and 0x2C. Bit b of word n enables channel 32n+b.
- R5: A write to an enable word changes only the byte lanes whose `reg_be` bit is set. Lane k covers bits 8k+7..8k.
- R6: The interrupt enable register is at address 0x04, in bits 2..0. Bit k gates `usr_irq[k]` onto `mgmt_irq[k]`. Bits 31..3 read as 0.
- R7: The bus enable is bit 0 at address 0x08. When it is clear, `mgmt_bus_rdata` is 0 and `mgmt_bus_ack` is 0. When it is set, both pass `usr_bus_rdata` and `usr_bus_ack` through unchanged.
- R8: A read of address 0x00 returns the synchronized power-good flags, two edges after a change on `pg_raw`. The layout is bit 0 user-2 analog, bit 1 user-1 analog, bit 2 user-2 core, bit 3 user-1 core. Bits 31..4 read 0.
- R9: A write to address 0x00 is ignored: later reads still return the live status.
- R10: After reset every enable is 0, so `mgmt_la`, `mgmt_irq`, `mgmt_bus_rdata` and `mgmt_bus_ack` are all 0.
- R11: Reads are combinational in the cycle `reg_sel`=1 and `reg_we`=0. Enable words read back what was written. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane write strobes |
| reg_rdata | output | 32 | Read data (combinational) |
| pg_raw | input | 4 | Asynchronous supply power-good flags |
| mgmt_out | input | 32 | Management signals bound for the user domain |
| usr_out | output | 32 | Isolated copy of `mgmt_out` |
| usr_oe | output | 1 | Output enable toward the user domain |
| usr_la | input | 128 | Logic-analyzer inputs from the user domain |
| mgmt_la | output | 128 | Gated logic-analyzer inputs |
| usr_irq | input | 3 | User interrupts |
| mgmt_irq | output | 3 | Gated interrupts |
| usr_bus_rdata | input | 32 | User bus read data |
| usr_bus_ack | input | 1 | User bus acknowledge |
| mgmt_bus_rdata | output | 32 | Gated bus read data |
| mgmt_bus_ack | output | 1 | Gated acknowledge |

## Verification
The input gates and the register read path are combinational. Their results are due in the same cycle as the stimulus, and the bench samples them 1 ns after the falling edge at which it drove the inputs. An enable write takes effect at the rising edge that follows the write strobe, so gated outputs are checked from the next falling edge on. A rising `pg_raw` bit appears in `usr_oe` and in the status readback only after two rising edges, so the bench checks it at the falling edges after the first and after the second rising edge. A falling core flag is checked 1 ns after it is driven, with no intervening edge.

// File: rtl/pd_iso_pkg.sv
// Shared constants of the power-domain isolation unit: register byte
// offsets and the position of the flag that gates outbound signals.
package pd_iso_pkg;
    localparam int PG_OFS       = 'h00;  // read-only supply status
    localparam int IRQ_OFS      = 'h04;  // interrupt enables
    localparam int BUS_OFS      = 'h08;  // bus return enable
    localparam int LA_OFS       = 'h20;  // first logic-analyzer enable word
    localparam int PG_CORE1_BIT = 3;     // user-1 core supply flag
endpackage

// File: rtl/pd_iso_sync.sv
// Multi-stage synchronizer for asynchronous level flags.
// Assumes each flag is a slow level; there is no pulse capture.
// Output is the last stage, reset to 0.
module pd_iso_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // first stage samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // each later stage re-samples the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) st[k] <= '0;
            else        st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/pd_iso_regs.sv
// Register file of the isolation unit: logic-analyzer enable words with
// byte-lane strobes, interrupt and bus enables, and a read-only status
// word. Assumes single-cycle accesses; reads are combinational.
module pd_iso_regs
    import pd_iso_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int LA_W  = 128,
    parameter int IRQ_W = 3,
    parameter int PG_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW/8-1:0]  be,
    input  logic [PG_W-1:0]  pg_status,
    output logic [DW-1:0]    rdata,
    output logic [LA_W-1:0]  la_en,
    output logic [IRQ_W-1:0] irq_en,
    output logic             bus_en
);
    localparam int NB       = DW / 8;
    localparam int LA_WORDS = LA_W / DW;

    logic [DW-1:0]       la_word [LA_WORDS];
    logic [LA_WORDS-1:0] la_hit;
    logic                irq_hit, bus_hit, pg_hit, wr, rd;

    assign wr      = sel & we;
    assign rd      = sel & ~we;
    assign irq_hit = (addr == AW'(IRQ_OFS));
    assign bus_hit = (addr == AW'(BUS_OFS));
    assign pg_hit  = (addr == AW'(PG_OFS));

    for (genvar w = 0; w < LA_WORDS; w++) begin : g_la
        assign la_hit[w] = (addr == AW'(LA_OFS + w * NB));
        assign la_en[w*DW +: DW] = la_word[w];

        // byte-lane update of one logic-analyzer enable word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                la_word[w] <= '0;
            end else if (wr && la_hit[w]) begin
                for (int b = 0; b < NB; b++)
                    if (be[b]) la_word[w][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // interrupt and bus enables, carried in byte lane 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
            bus_en <= 1'b0;
        end else if (wr && be[0]) begin
            if (irq_hit) irq_en <= wdata[IRQ_W-1:0];
            if (bus_hit) bus_en <= wdata[0];
        end
    end

    // combinational read decode; unmapped addresses return zero
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (pg_hit)  rdata = DW'(pg_status);
            if (irq_hit) rdata = DW'(irq_en);
            if (bus_hit) rdata = DW'(bus_en);
            for (int w = 0; w < LA_WORDS; w++)
                if (la_hit[w]) rdata = la_word[w];
        end
    end
endmodule

// File: rtl/pd_iso_gate.sv
// Boundary gates: outbound signals forced to zero unless released,
// inbound signals ANDed bit by bit with their enables.
// Purely combinational; assumes enables come from registers.
module pd_iso_gate #(
    parameter int DW    = 32,
    parameter int LA_W  = 128,
    parameter int IRQ_W = 3,
    parameter int MO_W  = 32
) (
    input  logic             release_out,
    input  logic [MO_W-1:0]  mgmt_out,
    output logic [MO_W-1:0]  usr_out,
    input  logic [LA_W-1:0]  la_en,
    input  logic [LA_W-1:0]  usr_la,
    output logic [LA_W-1:0]  mgmt_la,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic [IRQ_W-1:0] usr_irq,
    output logic [IRQ_W-1:0] mgmt_irq,
    input  logic             bus_en,
    input  logic [DW-1:0]    usr_bus_rdata,
    input  logic             usr_bus_ack,
    output logic [DW-1:0]    mgmt_bus_rdata,
    output logic             mgmt_bus_ack
);
    // outbound: hold at zero while the user supply is not released
    assign usr_out = release_out ? mgmt_out : '0;

    // inbound: per-bit AND so masked floating inputs resolve to zero
    assign mgmt_la        = usr_la & la_en;
    assign mgmt_irq       = usr_irq & irq_en;
    assign mgmt_bus_rdata = usr_bus_rdata & {DW{bus_en}};
    assign mgmt_bus_ack   = usr_bus_ack & bus_en;
endmodule

// File: rtl/pd_iso_unit.sv
// Top of the power-domain boundary isolation unit. It synchronizes the
// supply flags, holds the enable registers and gates both directions.
// Assumes pg_raw is asynchronous and that the register port belongs to
// the management domain only.
module pd_iso_unit
    import pd_iso_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int LA_W  = 128,
    parameter int IRQ_W = 3,
    parameter int PG_W  = 4,
    parameter int MO_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [DW/8-1:0]  reg_be,
    output logic [DW-1:0]    reg_rdata,
    input  logic [PG_W-1:0]  pg_raw,
    input  logic [MO_W-1:0]  mgmt_out,
    output logic [MO_W-1:0]  usr_out,
    output logic             usr_oe,
    input  logic [LA_W-1:0]  usr_la,
    output logic [LA_W-1:0]  mgmt_la,
    input  logic [IRQ_W-1:0] usr_irq,
    output logic [IRQ_W-1:0] mgmt_irq,
    input  logic [DW-1:0]    usr_bus_rdata,
    input  logic             usr_bus_ack,
    output logic [DW-1:0]    mgmt_bus_rdata,
    output logic             mgmt_bus_ack
);
    logic [PG_W-1:0]  pg_sync;
    logic [LA_W-1:0]  la_en;
    logic [IRQ_W-1:0] irq_en;
    logic             bus_en;

    pd_iso_sync #(.W(PG_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pg_raw), .q(pg_sync)
    );

    pd_iso_regs #(
        .DW(DW), .AW(AW), .LA_W(LA_W), .IRQ_W(IRQ_W), .PG_W(PG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .be(reg_be),
        .pg_status(pg_sync), .rdata(reg_rdata),
        .la_en(la_en), .irq_en(irq_en), .bus_en(bus_en)
    );

    // release needs the synchronized flag; removal uses the raw flag
    assign usr_oe = pg_sync[PG_CORE1_BIT] & pg_raw[PG_CORE1_BIT];

    pd_iso_gate #(
        .DW(DW), .LA_W(LA_W), .IRQ_W(IRQ_W), .MO_W(MO_W)
    ) u_gate (
        .release_out(usr_oe), .mgmt_out(mgmt_out), .usr_out(usr_out),
        .la_en(la_en), .usr_la(usr_la), .mgmt_la(mgmt_la),
        .irq_en(irq_en), .usr_irq(usr_irq), .mgmt_irq(mgmt_irq),
        .bus_en(bus_en), .usr_bus_rdata(usr_bus_rdata),
        .usr_bus_ack(usr_bus_ack), .mgmt_bus_rdata(mgmt_bus_rdata),
        .mgmt_bus_ack(mgmt_bus_ack)
    );
endmodule

// File: rtl/pd_iso_chk.sv
// Property checker for pd_iso_unit, attached through bind.
module pd_iso_chk #(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int LA_W  = 128,
    parameter int IRQ_W = 3,
    parameter int PG_W  = 4,
    parameter int MO_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_we,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_rdata,
    input logic [PG_W-1:0]  pg_raw,
    input logic [MO_W-1:0]  usr_out,
    input logic             usr_oe,
    input logic [LA_W-1:0]  usr_la,
    input logic [LA_W-1:0]  mgmt_la,
    input logic [IRQ_W-1:0] usr_irq,
    input logic [IRQ_W-1:0] mgmt_irq,
    input logic [DW-1:0]    usr_bus_rdata,
    input logic             usr_bus_ack,
    input logic [DW-1:0]    mgmt_bus_rdata,
    input logic             mgmt_bus_ack
);
    // R1
    oe_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_oe |-> pg_raw[3]);
    // R1
    out_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !usr_oe |-> (usr_out == '0));
    // R2
    release_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_raw[3] |-> ##2 !usr_oe);
    // R3
    la_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_la & ~usr_la) == '0);
    // R6
    irq_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_irq & ~usr_irq) == '0);
    // R7
    ack_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_bus_ack |-> usr_bus_ack);
    // R7
    bus_data_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_bus_rdata & ~usr_bus_rdata) == '0);
    // R8
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_we && reg_addr == '0) |-> (reg_rdata[DW-1:PG_W] == '0));
    // R10
    reset_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mgmt_la == '0 && mgmt_irq == '0 && !mgmt_bus_ack));
endmodule

bind pd_iso_unit pd_iso_chk u_chk (.*);

// File: tb/tb_pd_iso_unit.sv
module tb_pd_iso_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_sel = 1'b0, reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [3:0]   reg_be = '0;
    logic [31:0]  reg_rdata;
    logic [3:0]   pg_raw = '0;
    logic [31:0]  mgmt_out = '0, usr_out;
    logic         usr_oe;
    logic [127:0] usr_la = '1, mgmt_la;
    logic [2:0]   usr_irq = '1, mgmt_irq;
    logic [31:0]  usr_bus_rdata = '1, mgmt_bus_rdata;
    logic         usr_bus_ack = 1'b1, mgmt_bus_ack;

    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    pd_iso_unit dut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_be = '0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state: every inbound path blocked
        chk("R10 la", mgmt_la, '0);
        chk("R10 irq", 128'(mgmt_irq), '0);
        chk("R10 bus", {mgmt_bus_ack, mgmt_bus_rdata}, '0);
        for (int n = 0; n < 4; n++) begin
            rd(8'(8'h20 + 4*n), r);
            chk("R10 la word", 128'(r), '0);
        end
        chk("R1 oe low without power", {usr_oe, usr_out}, '0);
        // R3 floating inputs behind cleared enables
        usr_la = 'x; usr_irq = 'x; #1;
        chk("R3 floating la masked", mgmt_la, '0);
        chk("R10 floating irq masked", 128'(mgmt_irq), '0);
        usr_la = '1; usr_irq = '1;

        // R4 walking enable across every channel
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < 32; i++) begin
                wr(8'(8'h20 + 4*n), 32'(1) << i, 4'hF);
                chk("R4 channel map", mgmt_la, 128'(1) << (32*n + i));
            end
            wr(8'(8'h20 + 4*n), '0, 4'hF);
        end
        // R3 pattern gating with partial enables
        wr(8'h20, 32'hFFFF_0000, 4'hF);
        wr(8'h2C, 32'h0F0F_F0F0, 4'hF);
        usr_la = {4{32'hA5C3_0F96}}; #1;
        chk("R3 pattern", mgmt_la, {4{32'hA5C3_0F96}} &
            {32'h0F0F_F0F0, 32'h0, 32'h0, 32'hFFFF_0000});
        usr_la = '1;

        // R5 every byte-lane strobe combination
        for (int be = 0; be < 16; be++) begin
            logic [31:0] m;
            m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            wr(8'h24, '0, 4'hF);
            wr(8'h24, 32'hDEAD_BEEF, 4'(be));
            rd(8'h24, r);
            chk("R5 lane readback", 128'(r), 128'(32'hDEAD_BEEF & m));
            chk("R5 lane gating", 128'(mgmt_la[63:32]), 128'(32'hDEAD_BEEF & m));
        end

        // R11 readback and unmapped addresses
        wr(8'h2C, 32'h1234_5678, 4'hF);
        rd(8'h2C, r);
        chk("R11 readback", 128'(r), 128'(32'h1234_5678));
        wr(8'h40, 32'hFFFF_FFFF, 4'hF);
        rd(8'h40, r);
        chk("R11 unmapped write", 128'(r), '0);
        rd(8'h10, r);
        chk("R11 unmapped read", 128'(r), '0);

        // R6 every enable against every interrupt pattern
        for (int e = 0; e < 8; e++) begin
            wr(8'h04, {29'h1FFF_FFFF, 3'(e)}, 4'hF);
            rd(8'h04, r);
            chk("R6 irq readback", 128'(r), 128'(e));
            for (int v = 0; v < 8; v++) begin
                usr_irq = 3'(v); #1;
                chk("R6 irq gate", 128'(mgmt_irq), 128'(v & e));
            end
        end

        // R7 bus enable off and on
        for (int e = 0; e < 2; e++) begin
            wr(8'h08, 32'(e), 4'hF);
            for (int p = 0; p < 4; p++) begin
                usr_bus_rdata = 32'h1357_9BDF ^ (32'(p) * 32'h1111_1111);
                usr_bus_ack = p[0]; #1;
                chk("R7 bus gate", {mgmt_bus_ack, mgmt_bus_rdata},
                    e ? 128'({usr_bus_ack, usr_bus_rdata}) : '0);
            end
        end

        // R8 status readback over all flag values, R9 write ignored
        for (int p = 0; p < 16; p++) begin
            @(negedge clk); pg_raw = 4'(p);
            @(negedge clk);
            @(negedge clk);
            rd(8'h00, r);
            chk("R8 status", 128'(r), 128'(p));
            wr(8'h00, 32'hFFFF_FFFF, 4'hF);
            rd(8'h00, r);
            chk("R9 status write ignored", 128'(r), 128'(p));
        end

        // R1 R2 release and removal of outbound signals
        mgmt_out = 32'hCAFE_F00D;
        @(negedge clk); pg_raw = 4'h7;
        repeat (3) @(negedge clk);
        #1 chk("R2 other flags ignored", {usr_oe, usr_out}, '0);
        pg_raw = 4'h8; #1;
        chk("R2 release edge 0", 128'(usr_oe), '0);
        @(negedge clk); #1;
        chk("R2 release edge 1", {usr_oe, usr_out}, '0);
        @(negedge clk); #1;
        chk("R2 release edge 2", 128'({usr_oe, usr_out}), 128'({1'b1, 32'hCAFE_F00D}));
        mgmt_out = 32'h0BAD_C0DE; #1;
        chk("R1 pass through", 128'(usr_out), 128'(32'h0BAD_C0DE));
        pg_raw = 4'h7; #1;
        chk("R2 immediate removal", {usr_oe, usr_out}, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule